// File: doc/BRIEF.md
# Critical-Section Call Queue

This block sits next to an accelerator core and lets a group of small cores hand their critical sections to it. When a small core reaches a critical section it does not run the code itself. Instead it posts a call on its own port. The call carries a lock identifier, the target program counter and the stack pointer. The queue records which port the call came from, so each stored entry holds the full call context together with the requester's number.

Calls that arrive in the same cycle are taken one per cycle by a rotating-priority arbiter and stored in order of acceptance. The accelerator receives them one at a time on a valid/ready dispatch stream. After it accepts a call, no further call is offered until it raises its completion strobe. That strobe is turned into a one-cycle done pulse on the line of the core that made the call. The small core stays stalled from posting its call until it sees that pulse.

Back-pressure rules: a call port's ready may depend on its valid, and a call counts as accepted in any cycle where both are high. A core must hold its fields steady while valid is high and ready is low. On the dispatch side the queue holds valid and all payload steady until ready is seen.

Top module: `cs_req_buffer`

## Requirements
- R1: After reset, no dispatch is offered, every done line is low, and no call ready is high while no call valid is high.
- R2: In any cycle at most one call ready is high, and only on a port whose valid is high.
- R3: Among calls waiting at the same time, acceptance rotates: the next port granted is the first waiting port after the last granted one, in increasing index order with wrap-around. After reset, port 0 has first priority.
- R4: Calls are dispatched in the order they were accepted. Each dispatch carries the lock, PC and stack pointer exactly as posted, and the core number equals the index of the port that posted the call.
- R5: With DEPTH calls stored, every call ready stays low. Once a dispatch frees a slot, a waiting port is accepted again.
- R6: While a dispatched call has not completed, no further dispatch is offered. The cycle after a dispatch handshake, exec_valid is low.
- R7: An exec_done sampled while a call is outstanding produces a done pulse one cycle later, lasting exactly one cycle, on bit k of resp_done only, where k is that call's core number.
- R8: An exec_done sampled while no call is outstanding has no effect: no done pulse follows, and the queued calls are unchanged.
- R9: While exec_valid is high and exec_ready is low, exec_valid and the whole dispatch payload stay unchanged into the next cycle.
- R10: A call acceptance and a dispatch handshake in the same cycle both take effect. A completion and a call acceptance in the same cycle also both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_valid | input | N_CORES | Per-core call request valid |
| call_ready | output | N_CORES | Per-core call accept |
| call_lock | input | N_CORES*LOCK_W | Per-core lock identifier, core i at slice i |
| call_pc | input | N_CORES*ADDR_W | Per-core target program counter |
| call_sp | input | N_CORES*ADDR_W | Per-core stack pointer |
| exec_valid | output | 1 | Dispatch offered to accelerator |
| exec_ready | input | 1 | Accelerator takes the dispatch |
| exec_lock | output | LOCK_W | Dispatched lock identifier |
| exec_pc | output | ADDR_W | Dispatched target PC |
| exec_sp | output | ADDR_W | Dispatched stack pointer |
| exec_core | output | clog2(N_CORES) | Dispatched requester number |
| exec_done | input | 1 | Accelerator finished the current call |
| resp_done | output | N_CORES | One-cycle done pulse per core |

## Verification
Two pairs of events can fall in the same cycle. A new call can be accepted while the head entry is handed to the accelerator, and a completion can arrive while another core's call is accepted. The bench provokes both by raising a call valid at the same falling edge where it raises exec_ready or exec_done. It then judges the outcome by the ready seen in that cycle, by exec_valid dropping the cycle after, by the done pulse landing on the right core, and by later dispatches coming out in the expected order with intact fields.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;

  typedef enum logic {
    SLOT_FREE = 1'b0,
    SLOT_BUSY = 1'b1
  } slot_e;

  // width of a core number, at least one bit
  function automatic int id_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cs_rr_arb.sv
`timescale 1ns/1ps
module cs_rr_arb #(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [CW-1:0] gnt_idx
);

  logic [CW-1:0] prio;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(prio) + k) % N;
      if (!found && en && req[idx]) begin
        gnt[idx] = 1'b1;
        gnt_idx  = idx[CW-1:0];
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio <= '0;
    end else if (found) begin
      prio <= (gnt_idx == CW'(N-1)) ? '0 : gnt_idx + 1'b1;
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/cs_fifo.sv
`timescale 1ns/1ps
module cs_fifo #(
  parameter int W     = 98,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);

  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;

  assign full  = (count == CNTW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

  // R10
  both_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));

endmodule

// File: rtl/cs_dispatch.sv
`timescale 1ns/1ps
module cs_dispatch
  import cs_pkg::*;
#(
  parameter int N  = 4,
  parameter int CW = 2,
  parameter int W  = 98
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_valid,
  input  logic [W-1:0]  head_data,
  input  logic [CW-1:0] head_core,
  input  logic          exec_ready,
  input  logic          exec_done,
  output logic          exec_valid,
  output logic          pop,
  output logic [N-1:0]  resp_done
);

  slot_e         state;
  logic [CW-1:0] owner;

  assign exec_valid = head_valid && (state == SLOT_FREE);
  assign pop        = exec_valid && exec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SLOT_FREE;
      owner     <= '0;
      resp_done <= '0;
    end else begin
      resp_done <= '0;
      if (pop) begin
        state <= SLOT_BUSY;
        owner <= head_core;
      end else if (state == SLOT_BUSY && exec_done) begin
        state <= SLOT_FREE;
        for (int i = 0; i < N; i++) resp_done[i] <= (owner == CW'(i));
      end
    end
  end

  // R6
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_ready) |=> !exec_valid);

  // R9
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !exec_ready) |=> (exec_valid && $stable(head_data)));

  // R7
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resp_done));

  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|resp_done) |-> $past(exec_done));

endmodule

// File: rtl/cs_req_buffer.sv
`timescale 1ns/1ps
module cs_req_buffer
  import cs_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int DEPTH   = 8,
  parameter int LOCK_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_CORES-1:0]              call_valid,
  output logic [N_CORES-1:0]              call_ready,
  input  logic [N_CORES*LOCK_W-1:0]       call_lock,
  input  logic [N_CORES*ADDR_W-1:0]       call_pc,
  input  logic [N_CORES*ADDR_W-1:0]       call_sp,
  output logic                            exec_valid,
  input  logic                            exec_ready,
  output logic [LOCK_W-1:0]               exec_lock,
  output logic [ADDR_W-1:0]               exec_pc,
  output logic [ADDR_W-1:0]               exec_sp,
  output logic [id_w(N_CORES)-1:0]        exec_core,
  input  logic                            exec_done,
  output logic [N_CORES-1:0]              resp_done
);

  localparam int CW = id_w(N_CORES);
  localparam int EW = CW + LOCK_W + 2 * ADDR_W;

  logic [N_CORES-1:0] gnt;
  logic [CW-1:0]      gnt_idx;
  logic               fifo_full, fifo_empty, fifo_pop, fifo_push;
  logic [EW-1:0]      fifo_din, fifo_dout;
  logic [LOCK_W-1:0]  sel_lock;
  logic [ADDR_W-1:0]  sel_pc, sel_sp;

  cs_rr_arb #(.N(N_CORES), .CW(CW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (call_valid),
    .en      (!fifo_full),
    .gnt     (gnt),
    .gnt_idx (gnt_idx)
  );

  always_comb begin
    sel_lock = '0;
    sel_pc   = '0;
    sel_sp   = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (gnt[i]) begin
        sel_lock = call_lock[i*LOCK_W +: LOCK_W];
        sel_pc   = call_pc[i*ADDR_W +: ADDR_W];
        sel_sp   = call_sp[i*ADDR_W +: ADDR_W];
      end
    end
  end

  assign call_ready = gnt;
  assign fifo_push  = |gnt;
  assign fifo_din   = {gnt_idx, sel_lock, sel_pc, sel_sp};

  cs_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .din   (fifo_din),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  assign {exec_core, exec_lock, exec_pc, exec_sp} = fifo_dout;

  cs_dispatch #(.N(N_CORES), .CW(CW), .W(EW)) u_disp (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (!fifo_empty),
    .head_data  (fifo_dout),
    .head_core  (exec_core),
    .exec_ready (exec_ready),
    .exec_done  (exec_done),
    .exec_valid (exec_valid),
    .pop        (fifo_pop),
    .resp_done  (resp_done)
  );

endmodule

// File: tb/cs_req_buffer_tb.sv
`timescale 1ns/1ps
module cs_req_buffer_tb;
  import cs_pkg::*;

  localparam int N  = 4;
  localparam int D  = 8;
  localparam int LW = 32;
  localparam int AW = 32;
  localparam int CW = id_w(N);
  localparam int EW = CW + LW + 2 * AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    call_valid = '0;
  logic [N-1:0]    call_ready;
  logic [N*LW-1:0] call_lock = '0;
  logic [N*AW-1:0] call_pc = '0;
  logic [N*AW-1:0] call_sp = '0;
  logic            exec_valid;
  logic            exec_ready = 1'b0;
  logic [LW-1:0]   exec_lock;
  logic [AW-1:0]   exec_pc, exec_sp;
  logic [CW-1:0]   exec_core;
  logic            exec_done = 1'b0;
  logic [N-1:0]    resp_done;

  int tests = 0;
  int fails = 0;
  int last_gnt = N - 1;
  int seq = 0;
  logic [EW-1:0] model[$];

  always #2.5 clk = ~clk;

  cs_req_buffer #(.N_CORES(N), .DEPTH(D), .LOCK_W(LW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .call_valid(call_valid), .call_ready(call_ready),
    .call_lock(call_lock), .call_pc(call_pc), .call_sp(call_sp),
    .exec_valid(exec_valid), .exec_ready(exec_ready),
    .exec_lock(exec_lock), .exec_pc(exec_pc), .exec_sp(exec_sp),
    .exec_core(exec_core), .exec_done(exec_done), .resp_done(resp_done)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int next_rr(input int last, input logic [N-1:0] mask);
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (last + k) % N;
      if (mask[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic load_fields(input int c);
    seq++;
    call_lock[c*LW +: LW] = 32'h1000_0000 + seq;
    call_pc[c*AW +: AW]   = 32'h2000_0000 + seq * 16 + c;
    call_sp[c*AW +: AW]   = 32'h3000_0000 - seq * 64;
  endtask

  function automatic logic [EW-1:0] entry_of(input int c);
    return {CW'(c), call_lock[c*LW +: LW], call_pc[c*AW +: AW], call_sp[c*AW +: AW]};
  endfunction

  // post one call from core c and wait for its acceptance
  task automatic post(input int c);
    @(negedge clk);
    load_fields(c);
    call_valid[c] = 1'b1;
    #1;
    for (int w = 0; w < 50 && !call_ready[c]; w++) begin
      @(negedge clk);
      #1;
    end
    check("R2 accept on posting port", {127'd0, call_ready[c]}, 128'd1);
    model.push_back(entry_of(c));
    last_gnt = c;
    @(posedge clk);
    @(negedge clk);
    call_valid[c] = 1'b0;
  endtask

  // take the head dispatch, complete it, check the done pulse
  task automatic serve();
    logic [EW-1:0] exp;
    int c;
    exp = model.pop_front();
    c = int'(exp[EW-1 -: CW]);
    @(negedge clk);
    #1;
    for (int w = 0; w < 50 && !exec_valid; w++) begin
      @(negedge clk);
      #1;
    end
    check("R4 dispatch order and fields", {30'd0, exec_core, exec_lock, exec_pc, exec_sp}, {30'd0, exp});
    exec_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exec_ready = 1'b0;
    #1;
    check("R6 no dispatch while outstanding", {127'd0, exec_valid}, 128'd0);
    exec_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exec_done = 1'b0;
    #1;
    check("R7 done to requester", {124'd0, resp_done}, 128'd1 << c);
  endtask

  task automatic t_reset();
    #1;
    check("R1 no dispatch after reset", {127'd0, exec_valid}, 128'd0);
    check("R1 done low after reset", {124'd0, resp_done}, 128'd0);
    check("R1 ready low after reset", {124'd0, call_ready}, 128'd0);
  endtask

  task automatic t_single();
    logic [EW-1:0] snap;
    post(2);
    post(0);
    @(negedge clk);
    #1;
    snap = {exec_core, exec_lock, exec_pc, exec_sp};
    check("R9 offered while waiting", {127'd0, exec_valid}, 128'd1);
    @(negedge clk);
    #1;
    check("R9 payload held", {30'd0, exec_core, exec_lock, exec_pc, exec_sp}, {30'd0, snap});
    check("R9 valid held", {127'd0, exec_valid}, 128'd1);
    serve();
    @(negedge clk);
    #1;
    check("R7 done lasts one cycle", {124'd0, resp_done}, 128'd0);
    serve();
  endtask

  task automatic t_round_robin();
    logic [N-1:0] mask;
    int g;
    mask = 4'b1011;
    @(negedge clk);
    for (int c = 0; c < N; c++) if (mask[c]) load_fields(c);
    call_valid = mask;
    for (int k = 0; k < 3; k++) begin
      #1;
      g = next_rr(last_gnt, mask);
      check("R3 rotating grant", {124'd0, call_ready}, 128'd1 << g);
      model.push_back(entry_of(g));
      last_gnt = g;
      @(posedge clk);
      @(negedge clk);
      mask[g] = 1'b0;
      call_valid = mask;
    end
    serve();
    serve();
    serve();
  endtask

  task automatic t_full();
    for (int k = 0; k < D; k++) post(1);
    @(negedge clk);
    load_fields(2);
    call_valid[2] = 1'b1;
    #1;
    check("R5 no accept when full", {124'd0, call_ready}, 128'd0);
    @(negedge clk);
    #1;
    check("R5 still blocked when full", {124'd0, call_ready}, 128'd0);
    call_valid[2] = 1'b0;
    serve();
    @(negedge clk);
    load_fields(2);
    call_valid[2] = 1'b1;
    #1;
    check("R5 accept after slot frees", {124'd0, call_ready}, 128'd1 << 2);
    model.push_back(entry_of(2));
    last_gnt = 2;
    @(posedge clk);
    @(negedge clk);
    call_valid[2] = 1'b0;
    for (int k = 0; k < D; k++) serve();
  endtask

  task automatic t_same_cycle();
    logic [EW-1:0] a;
    post(3);
    a = model.pop_front();
    @(negedge clk);
    load_fields(0);
    call_valid[0] = 1'b1;
    exec_ready = 1'b1;
    #1;
    check("R10 accept during dispatch", {124'd0, call_ready}, 128'd1);
    check("R10 dispatch during accept", {30'd0, exec_core, exec_lock, exec_pc, exec_sp}, {30'd0, a});
    model.push_back(entry_of(0));
    last_gnt = 0;
    @(posedge clk);
    @(negedge clk);
    call_valid[0] = 1'b0;
    exec_ready = 1'b0;
    #1;
    check("R10 busy after dispatch", {127'd0, exec_valid}, 128'd0);
    @(negedge clk);
    load_fields(1);
    call_valid[1] = 1'b1;
    exec_done = 1'b1;
    #1;
    check("R10 accept during completion", {124'd0, call_ready}, 128'd1 << 1);
    model.push_back(entry_of(1));
    last_gnt = 1;
    @(posedge clk);
    @(negedge clk);
    call_valid[1] = 1'b0;
    exec_done = 1'b0;
    #1;
    check("R10 done during accept", {124'd0, resp_done}, 128'd1 << 3);
    serve();
    serve();
  endtask

  task automatic t_stray_done();
    post(3);
    @(negedge clk);
    exec_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exec_done = 1'b0;
    #1;
    check("R8 stray done gives no pulse", {124'd0, resp_done}, 128'd0);
    @(negedge clk);
    #1;
    check("R8 no late pulse", {124'd0, resp_done}, 128'd0);
    serve();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single();
    t_round_robin();
    t_full();
    t_same_cycle();
    t_stray_done();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule